// File: doc/BRIEF.md
# Display Controller Register and Interrupt Unit

This block is the control and status register set of a display controller that has one graphics layer and two output paths, a panel (LCD) path and a digital path. A host reaches it through a simple request bus of 32-bit words. It keeps the timing, size, position, attribute, colour-key, threshold, increment and base-address settings, and drives the decoded enables that the pixel pipeline needs: panel enable, digital enable, remote-framebuffer mode, layer enable and pixel format. It also holds a 16-bit interrupt status register, which event inputs set and software clears by writing ones, and a level interrupt gated by an enable register. A bit in the system-configuration register returns the whole unit to its reset state.

A small access state machine sequences the bus. In IDLE, `ready` is high and a request is accepted on a clock edge. A write updates the registers at that edge and the machine stays in IDLE. A read moves it to RDATA, where `rvalid` and `rdata` are presented for one cycle before the return to IDLE. A soft-reset write moves it to SRST, which holds `ready` low for one cycle and then goes back to IDLE. The one-cycle flags `invalidate`, `be_err`, `bad_addr` and `bad_width` are high in the cycle after the accepting edge.

Writes to the video-scaler range (offsets 0x0BC..0x140 and 0x14C..0x1DC) are taken without effect, and reads there return zero.

Top module: `disp_ctrl_regs`

## Requirements
- R1: After reset, capability (0x048) reads 0x161, row increment (0x0AC) and pixel increment (0x0B0) read 1, and every other stored register reads 0. Revision (0x000) always reads 0x20, system status (0x014) 1, line status (0x05C) 0x7FF and layer FIFO size (0x0A8) 256.
- R2: `ready` is high in IDLE. An accepted read gives `rvalid` high for exactly the next cycle with `rdata` valid. An accepted write takes effect at its accepting edge.
- R3: Stored values are masked: config (0x044) 0x3FFF, capability 0x3FF, colours (0x04C, 0x050, 0x054, 0x058) 0xFFFFFF, line number (0x060) 0x7FF, horizontal/vertical timing (0x064, 0x068) 0x0FF0FF3F, polarity (0x06C) 0x3FFFF, divisor (0x070) 0x00FF00FF, FIFO threshold (0x0A4) 0x01FF01FF. Base addresses (0x080, 0x084, 0x0B8), increments and window skip (0x0B4) keep all 32 bits.
- R4: The digital size (0x078), panel size (0x07C), layer size (0x08C) and layer position (0x088) registers hold an 11-bit X field in bits 10:0 and an 11-bit Y field in bits 26:16. The size registers hold width−1 and height−1 and read back in the same encoding, so after reset they read 0 (size 1).
- R5: Control (0x040) is stored masked with 0x07FF9FFF. Its bit 0 drives `lcd_en`, bit 1 drives `dig_en` and bit 11 drives `rfb_mode`.
- R6: Layer attributes (0x0A0) keep bits 10:0. Bit 0 drives `gfx_en` and bits 4:1 drive `gfx_fmt`. A write with bits 10:9 not both zero pulses `be_err`.
- R7: A high bit of `evt` sets the matching bit of interrupt status (0x018). Writing 0x018 clears the bits written as one and leaves the others. An event wins over a clear of the same bit in the same cycle.
- R8: Interrupt enable (0x01C) keeps the low 16 bits of a write. `irq` is high exactly when status AND enable is non-zero. It follows any change of either register in the cycle after the edge that made it.
- R9: A write to system configuration (0x010) with bit 1 set resets every register, including interrupt status and enable, then stores the written data masked with 0x301B as the idle-mode value. `ready` is low for the cycle that follows.
- R10: An access whose `size` is not 2 (a 4-byte word) changes nothing, reads 0 and pulses `bad_width`.
- R11: An access to an unaligned offset, or to an offset outside the map and outside the scaler range, changes nothing, reads 0 and pulses `bad_addr`. A scaler-range access reads 0 and raises no flag.
- R12: `invalidate` pulses after writes to control, config, colours, the three size registers, position, base addresses, attributes and the two increments. Writes to other registers do not pulse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte offset |
| size | input | 2 | Access width code; 2 = 32-bit word |
| wdata | input | 32 | Write data |
| evt | input | IRQ_W | Interrupt event set strobes |
| ready | output | 1 | Request can be accepted |
| rvalid | output | 1 | Read data valid |
| rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt |
| lcd_en | output | 1 | Panel output enable |
| dig_en | output | 1 | Digital output enable |
| rfb_mode | output | 1 | Remote-framebuffer output mode |
| gfx_en | output | 1 | Graphics layer enable |
| gfx_fmt | output | 4 | Graphics pixel format |
| invalidate | output | 1 | Image-affecting write pulse |
| be_err | output | 1 | Unsupported big-endian format pulse |
| bad_addr | output | 1 | Unmapped or unaligned access pulse |
| bad_width | output | 1 | Non-word access pulse |

## Verification
The bench targets the following corner cases:
- **Status clears.** The bench clears a status bit that is not set, then clears one that is set. A design that cleared by plain write instead of write-one-to-clear would lose unrelated bits.
- **Same-cycle set and clear.** The bench raises an event in the same cycle as a clear of that bit. A design with the wrong priority would drop the event.
- **Soft reset.** The bench checks that soft reset clears the interrupt registers and the enables, yet keeps the masked idle value from the same write.
- **Enable masking.** It checks that disabled status bits keep `irq` low.
- **Bad accesses.** Bad-width, unaligned, unmapped and scaler-range accesses are each compared against the register they could have corrupted.
- **Randomised writes.** Random full-word writes across the whole register set expose a wrong mask, a missing minus-one field or an `invalidate` pulse on the wrong register.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RDATA = 2'd1,
        ST_SRST  = 2'd2
    } acc_state_t;

    localparam logic [1:0] SZ_WORD = 2'd2;

    // registers decoded outside the table
    localparam logic [31:0] OFF_REV    = 32'h000;
    localparam logic [31:0] OFF_SYSCFG = 32'h010;
    localparam logic [31:0] OFF_SYSST  = 32'h014;
    localparam logic [31:0] OFF_ISTAT  = 32'h018;
    localparam logic [31:0] OFF_IEN    = 32'h01C;
    localparam logic [31:0] OFF_LSTAT  = 32'h05C;
    localparam logic [31:0] OFF_FIFO   = 32'h0A8;

    localparam logic [31:0] VAL_REV    = 32'h20;
    localparam logic [31:0] VAL_LSTAT  = 32'h7FF;
    localparam logic [31:0] VAL_FIFO   = 32'd256;
    localparam logic [31:0] MASK_IDLE  = 32'h0000_301B;

    localparam logic [31:0] HOLE_A_LO  = 32'h0BC;
    localparam logic [31:0] HOLE_A_HI  = 32'h140;
    localparam logic [31:0] HOLE_B_LO  = 32'h14C;
    localparam logic [31:0] HOLE_B_HI  = 32'h1DC;

    // table of plain stored registers
    localparam int NREG    = 24;
    localparam int IX_CTRL = 0;
    localparam int IX_ATTR = 18;

    localparam logic [31:0] REG_OFF [NREG] = '{
        32'h040, 32'h044, 32'h048, 32'h04C, 32'h050, 32'h054, 32'h058, 32'h060,
        32'h064, 32'h068, 32'h06C, 32'h070, 32'h078, 32'h07C, 32'h080, 32'h084,
        32'h088, 32'h08C, 32'h0A0, 32'h0A4, 32'h0AC, 32'h0B0, 32'h0B4, 32'h0B8};

    localparam logic [31:0] REG_MSK [NREG] = '{
        32'h07FF_9FFF, 32'h0000_3FFF, 32'h0000_03FF, 32'h00FF_FFFF,
        32'h00FF_FFFF, 32'h00FF_FFFF, 32'h00FF_FFFF, 32'h0000_07FF,
        32'h0FF0_FF3F, 32'h0FF0_FF3F, 32'h0003_FFFF, 32'h00FF_00FF,
        32'h07FF_07FF, 32'h07FF_07FF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'h07FF_07FF, 32'h07FF_07FF, 32'h0000_07FF, 32'h01FF_01FF,
        32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};

    localparam logic [31:0] REG_RST [NREG] = '{
        32'h0, 32'h0, 32'h161, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'h0, 32'h0, 32'h0,   32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'h0, 32'h0, 32'h0,   32'h0, 32'h1, 32'h1, 32'h0, 32'h0};

    // 1 = a write changes the displayed image
    localparam bit REG_IMG [NREG] = '{
        1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
        1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

endpackage

// File: rtl/dcr_access_fsm.sv
module dcr_access_fsm
    import dcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic we,
    input  logic soft_go,
    output logic ready,
    output logic accept,
    output logic rvalid
);

    acc_state_t st_q, st_nx;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req) begin
                    if (soft_go)  st_nx = ST_SRST;
                    else if (we)  st_nx = ST_IDLE;
                    else          st_nx = ST_RDATA;
                end
            end
            ST_RDATA: st_nx = ST_IDLE;
            ST_SRST:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        ready  = (st_q == ST_IDLE);
        accept = ready && req;
        rvalid = (st_q == ST_RDATA);
    end

endmodule

// File: rtl/dcr_irq_unit.sv
module dcr_irq_unit #(
    parameter int IRQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             stat_wr,
    input  logic             en_wr,
    input  logic [IRQ_W-1:0] wdata,
    input  logic [IRQ_W-1:0] evt,
    output logic [IRQ_W-1:0] status,
    output logic [IRQ_W-1:0] enable,
    output logic             irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else if (soft_clr) begin
            status <= '0;
            enable <= '0;
        end else begin
            // events take priority over a same-cycle clear
            status <= (stat_wr ? (status & ~wdata) : status) | evt;
            if (en_wr) enable <= wdata;
        end
    end

    assign irq = |(status & enable);

endmodule

// File: rtl/dcr_cfg_regs.sv
module dcr_cfg_regs
    import dcr_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int IRQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              soft_clr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [IRQ_W-1:0]  status,
    input  logic [IRQ_W-1:0]  enable,
    output logic [31:0]       rd_word,
    output logic              known,
    output logic              img_hit,
    output logic              be_hit,
    output logic              lcd_en,
    output logic              dig_en,
    output logic              rfb_mode,
    output logic              gfx_en,
    output logic [3:0]        gfx_fmt
);

    logic [31:0]     off;
    logic            aligned;
    logic            in_hole;
    logic [NREG-1:0] sel;
    logic [31:0]     reg_q [NREG];
    logic [31:0]     idle_q;

    assign off     = 32'(addr);
    assign aligned = (addr[1:0] == 2'b00);
    assign in_hole = aligned &&
                     (((off >= HOLE_A_LO) && (off <= HOLE_A_HI)) ||
                      ((off >= HOLE_B_LO) && (off <= HOLE_B_HI)));

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel[g] = (off == REG_OFF[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) reg_q[i] <= REG_RST[i];
        end else if (soft_clr) begin
            for (int i = 0; i < NREG; i++) reg_q[i] <= REG_RST[i];
        end else if (wr) begin
            for (int i = 0; i < NREG; i++)
                if (sel[i]) reg_q[i] <= wdata & REG_MSK[i];
        end
    end

    // idle value is written even by the soft-reset write itself
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          idle_q <= '0;
        else if (wr && (off == OFF_SYSCFG))  idle_q <= wdata & MASK_IDLE;
    end

    always_comb begin
        rd_word = '0;
        known   = 1'b0;
        img_hit = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (sel[i]) begin
                rd_word = reg_q[i];
                known   = 1'b1;
                img_hit = REG_IMG[i];
            end
        end
        case (off)
            OFF_REV:    begin rd_word = VAL_REV;          known = 1'b1; end
            OFF_SYSCFG: begin rd_word = idle_q;           known = 1'b1; end
            OFF_SYSST:  begin rd_word = 32'd1;            known = 1'b1; end
            OFF_ISTAT:  begin rd_word = 32'(status);      known = 1'b1; end
            OFF_IEN:    begin rd_word = 32'(enable);      known = 1'b1; end
            OFF_LSTAT:  begin rd_word = VAL_LSTAT;        known = 1'b1; end
            OFF_FIFO:   begin rd_word = VAL_FIFO;         known = 1'b1; end
            default:    if (in_hole) known = 1'b1;
        endcase
    end

    assign be_hit   = sel[IX_ATTR] && (wdata[10:9] != 2'b00);
    assign lcd_en   = reg_q[IX_CTRL][0];
    assign dig_en   = reg_q[IX_CTRL][1];
    assign rfb_mode = reg_q[IX_CTRL][11];
    assign gfx_en   = reg_q[IX_ATTR][0];
    assign gfx_fmt  = reg_q[IX_ATTR][4:1];

endmodule

// File: rtl/disp_ctrl_regs.sv
module disp_ctrl_regs
    import dcr_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int IRQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    input  logic [IRQ_W-1:0]  evt,
    output logic              ready,
    output logic              rvalid,
    output logic [31:0]       rdata,
    output logic              irq,
    output logic              lcd_en,
    output logic              dig_en,
    output logic              rfb_mode,
    output logic              gfx_en,
    output logic [3:0]        gfx_fmt,
    output logic              invalidate,
    output logic              be_err,
    output logic              bad_addr,
    output logic              bad_width
);

    logic             acc;
    logic             size_ok;
    logic             soft_go;
    logic             soft_clr;
    logic             wr_ok;
    logic             known;
    logic             img_hit;
    logic             be_hit;
    logic [31:0]      rd_word;
    logic [IRQ_W-1:0] ist_q;
    logic [IRQ_W-1:0] ien_q;

    assign size_ok  = (size == SZ_WORD);
    assign soft_go  = we && size_ok && (32'(addr) == OFF_SYSCFG) && wdata[1];
    assign soft_clr = acc && soft_go;
    assign wr_ok    = acc && we && size_ok && known;

    dcr_access_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .we      (we),
        .soft_go (soft_go),
        .ready   (ready),
        .accept  (acc),
        .rvalid  (rvalid)
    );

    dcr_cfg_regs #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_ok),
        .soft_clr (soft_clr),
        .addr     (addr),
        .wdata    (wdata),
        .status   (ist_q),
        .enable   (ien_q),
        .rd_word  (rd_word),
        .known    (known),
        .img_hit  (img_hit),
        .be_hit   (be_hit),
        .lcd_en   (lcd_en),
        .dig_en   (dig_en),
        .rfb_mode (rfb_mode),
        .gfx_en   (gfx_en),
        .gfx_fmt  (gfx_fmt)
    );

    dcr_irq_unit #(.IRQ_W(IRQ_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .stat_wr  (wr_ok && (32'(addr) == OFF_ISTAT)),
        .en_wr    (wr_ok && (32'(addr) == OFF_IEN)),
        .wdata    (wdata[IRQ_W-1:0]),
        .evt      (evt),
        .status   (ist_q),
        .enable   (ien_q),
        .irq      (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata      <= '0;
            invalidate <= 1'b0;
            be_err     <= 1'b0;
            bad_addr   <= 1'b0;
            bad_width  <= 1'b0;
        end else begin
            invalidate <= wr_ok && img_hit;
            be_err     <= wr_ok && be_hit;
            bad_width  <= acc && !size_ok;
            bad_addr   <= acc && size_ok && !known;
            if (acc && !we) rdata <= (size_ok && known) ? rd_word : 32'd0;
        end
    end

endmodule

// File: rtl/dcr_chk.sv
module dcr_chk
    import dcr_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int IRQ_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        size,
    input logic [IRQ_W-1:0]  wd,
    input logic [IRQ_W-1:0]  evt,
    input logic              accept,
    input logic              ready,
    input logic              rvalid,
    input logic              irq,
    input logic [IRQ_W-1:0]  enable,
    input logic              lcd_en,
    input logic              dig_en,
    input logic              bad_addr,
    input logic              bad_width,
    input logic              invalidate
);

    logic wr_word;
    assign wr_word = accept && we && (size == SZ_WORD);

    // R2
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !we |=> rvalid);

    // R2
    rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    // R7
    clear_all_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_word && (32'(addr) == OFF_ISTAT) && (wd == '1) && (evt == '0) |=> !irq);

    // R8
    enable_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_word && (32'(addr) == OFF_IEN) |=> enable == $past(wd));

    // R9
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_word && (32'(addr) == OFF_SYSCFG) && wd[1]
        |=> !ready && (enable == '0) && !lcd_en && !dig_en && !irq);

    // R10
    bad_width_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_width |-> $past(accept && (size != SZ_WORD)));

    // R11
    bad_addr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_addr |-> $past(accept && (size == SZ_WORD)));

    // R12
    invalidate_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |-> $past(wr_word));

endmodule

bind disp_ctrl_regs dcr_chk #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) u_dcr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (we),
    .addr       (addr),
    .size       (size),
    .wd         (wdata[IRQ_W-1:0]),
    .evt        (evt),
    .accept     (acc),
    .ready      (ready),
    .rvalid     (rvalid),
    .irq        (irq),
    .enable     (ien_q),
    .lcd_en     (lcd_en),
    .dig_en     (dig_en),
    .bad_addr   (bad_addr),
    .bad_width  (bad_width),
    .invalidate (invalidate)
);

// File: tb/test_disp_ctrl_regs.sv
module test_disp_ctrl_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 400;
    localparam int NRW        = 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [8:0]  addr = '0;
    logic [1:0]  size = 2'd2;
    logic [31:0] wdata = '0;
    logic [15:0] evt = '0;

    logic        ready, rvalid, irq, lcd_en, dig_en, rfb_mode, gfx_en;
    logic        invalidate, be_err, bad_addr, bad_width;
    logic [31:0] rdata;
    logic [3:0]  gfx_fmt;

    int checks = 0;
    int errors = 0;

    logic [31:0] s_rdata;
    logic        s_rvalid, s_ready, s_inv, s_be, s_ba, s_bw;
    logic [31:0] mdl [0:127];

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_ctrl_regs i_disp_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
        .wdata(wdata), .evt(evt), .ready(ready), .rvalid(rvalid), .rdata(rdata),
        .irq(irq), .lcd_en(lcd_en), .dig_en(dig_en), .rfb_mode(rfb_mode),
        .gfx_en(gfx_en), .gfx_fmt(gfx_fmt), .invalidate(invalidate),
        .be_err(be_err), .bad_addr(bad_addr), .bad_width(bad_width)
    );

    function automatic logic [31:0] mask_of(input logic [8:0] a);
        case (a)
            9'h010: mask_of = 32'h0000_301B;
            9'h01C: mask_of = 32'h0000_FFFF;
            9'h040: mask_of = 32'h07FF_9FFF;
            9'h044: mask_of = 32'h0000_3FFF;
            9'h048: mask_of = 32'h0000_03FF;
            9'h04C, 9'h050, 9'h054, 9'h058: mask_of = 32'h00FF_FFFF;
            9'h060: mask_of = 32'h0000_07FF;
            9'h064, 9'h068: mask_of = 32'h0FF0_FF3F;
            9'h06C: mask_of = 32'h0003_FFFF;
            9'h070: mask_of = 32'h00FF_00FF;
            9'h078, 9'h07C, 9'h088, 9'h08C: mask_of = 32'h07FF_07FF;
            9'h0A0: mask_of = 32'h0000_07FF;
            9'h0A4: mask_of = 32'h01FF_01FF;
            default: mask_of = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] rst_of(input logic [8:0] a);
        case (a)
            9'h048:         rst_of = 32'h161;
            9'h0AC, 9'h0B0: rst_of = 32'h1;
            default:        rst_of = 32'h0;
        endcase
    endfunction

    function automatic logic img_of(input logic [8:0] a);
        case (a)
            9'h040, 9'h044, 9'h04C, 9'h050, 9'h054, 9'h058, 9'h078, 9'h07C,
            9'h080, 9'h084, 9'h088, 9'h08C, 9'h0A0, 9'h0AC, 9'h0B0, 9'h0B8:
                img_of = 1'b1;
            default: img_of = 1'b0;
        endcase
    endfunction

    function automatic logic [8:0] rw_off(input int i);
        case (i)
            0: rw_off = 9'h010;  1: rw_off = 9'h01C;  2: rw_off = 9'h040;
            3: rw_off = 9'h044;  4: rw_off = 9'h048;  5: rw_off = 9'h04C;
            6: rw_off = 9'h050;  7: rw_off = 9'h054;  8: rw_off = 9'h058;
            9: rw_off = 9'h060; 10: rw_off = 9'h064; 11: rw_off = 9'h068;
           12: rw_off = 9'h06C; 13: rw_off = 9'h070; 14: rw_off = 9'h078;
           15: rw_off = 9'h07C; 16: rw_off = 9'h080; 17: rw_off = 9'h084;
           18: rw_off = 9'h088; 19: rw_off = 9'h08C; 20: rw_off = 9'h0A0;
           21: rw_off = 9'h0A4; 22: rw_off = 9'h0AC; 23: rw_off = 9'h0B0;
           24: rw_off = 9'h0B4; default: rw_off = 9'h0B8;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic bus(input logic w, input logic [8:0] a, input logic [31:0] d,
                       input logic [1:0] s);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; size = s;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        s_rdata = rdata; s_rvalid = rvalid; s_ready = ready;
        s_inv = invalidate; s_be = be_err; s_ba = bad_addr; s_bw = bad_width;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus(1'b1, a, d, 2'd2);
    endtask

    task automatic rd(input logic [8:0] a);
        bus(1'b0, a, 32'd0, 2'd2);
    endtask

    task automatic pulse_evt(input logic [15:0] v);
        @(negedge clk); evt = v;
        @(negedge clk); evt = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL R2 watchdog act hung exp finished");
        finish_run();
    end

    initial begin
        int seed_r;
        seed_r = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state at the ports
        check("R1 ready", 32'(ready), 32'd1);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 enables", {28'd0, lcd_en, dig_en, rfb_mode, gfx_en}, 32'd0);
        for (int i = 0; i < NRW; i++) begin
            rd(rw_off(i));
            check($sformatf("R1 reset %h", rw_off(i)), s_rdata, rst_of(rw_off(i)));
            mdl[rw_off(i) >> 2] = rst_of(rw_off(i));
        end
        rd(9'h000); check("R1 revision", s_rdata, 32'h20);
        check("R2 rvalid", 32'(s_rvalid), 32'd1);
        rd(9'h014); check("R1 sysstatus", s_rdata, 32'd1);
        rd(9'h05C); check("R1 line status", s_rdata, 32'h7FF);
        rd(9'h0A8); check("R1 fifo size", s_rdata, 32'd256);
        rd(9'h018); check("R1 irq status", s_rdata, 32'd0);

        // R3 R12 R6 constrained random writes and reads against the model
        for (int n = 0; n < NRAND; n++) begin
            logic [8:0]  a;
            logic [31:0] d;
            a = rw_off(int'($urandom_range(0, NRW - 1)));
            d = $urandom;
            if (a == 9'h010) d[1] = 1'b0;
            if ($urandom_range(0, 1) == 1) begin
                wr(a, d);
                mdl[a >> 2] = d & mask_of(a);
                check($sformatf("R12 invalidate %h", a), 32'(s_inv), 32'(img_of(a)));
                check($sformatf("R6 be_err %h", a), 32'(s_be),
                      32'((a == 9'h0A0) && (d[10:9] != 2'b00)));
            end else begin
                rd(a);
                check($sformatf("R3 readback %h", a), s_rdata, mdl[a >> 2]);
            end
        end

        // R4 minus-one size encoding
        wr(9'h078, 32'hFFFF_FFFF); rd(9'h078);
        check("R4 dig size", s_rdata, 32'h07FF_07FF);
        wr(9'h08C, 32'h0010_0020); rd(9'h08C);
        check("R4 gfx size", s_rdata, 32'h0010_0020);

        // R5 control decode
        wr(9'h040, 32'hFFFF_FFFF); rd(9'h040);
        check("R5 ctrl mask", s_rdata, 32'h07FF_9FFF);
        check("R5 outputs on", {29'd0, lcd_en, dig_en, rfb_mode}, 32'h7);
        wr(9'h040, 32'h0000_0002);
        check("R5 outputs dig only", {29'd0, lcd_en, dig_en, rfb_mode}, 32'h2);

        // R6 attributes
        wr(9'h0A0, 32'h0000_0019);
        check("R6 layer fields", {27'd0, gfx_en, gfx_fmt}, 32'h1C);
        check("R6 no be_err", 32'(s_be), 32'd0);
        wr(9'h0A0, 32'hFFFF_F200);
        check("R6 be_err", 32'(s_be), 32'd1);
        rd(9'h0A0); check("R6 attr keep", s_rdata, 32'h200);

        // R7 R8 interrupts
        wr(9'h01C, 32'h0000_0005);
        check("R8 irq idle", 32'(irq), 32'd0);
        wr(9'h018, 32'h0000_FFFF);
        pulse_evt(16'h0004);
        check("R8 irq enabled", 32'(irq), 32'd1);
        rd(9'h018); check("R7 status set", s_rdata, 32'h4);
        wr(9'h018, 32'h0000_0001);
        rd(9'h018); check("R7 other bits kept", s_rdata, 32'h4);
        check("R8 irq held", 32'(irq), 32'd1);
        wr(9'h018, 32'h0000_0004);
        check("R7 cleared irq", 32'(irq), 32'd0);
        pulse_evt(16'h0008);
        check("R8 masked event", 32'(irq), 32'd0);
        wr(9'h01C, 32'hFFFF_0008);
        check("R8 enable raises irq", 32'(irq), 32'd1);
        rd(9'h01C); check("R8 enable low16", s_rdata, 32'h8);
        evt = 16'h0008;
        wr(9'h018, 32'h0000_0008);
        evt = '0;
        rd(9'h018); check("R7 set wins", s_rdata, 32'h8);
        wr(9'h018, 32'hFFFF_FFFF);
        check("R7 clear all", 32'(irq), 32'd0);

        // R10 bad width
        wr(9'h040, 32'h0000_0001);
        bus(1'b1, 9'h040, 32'h0000_0002, 2'd1);
        check("R10 write flag", 32'(s_bw), 32'd1);
        check("R10 write ignored", {30'd0, lcd_en, dig_en}, 32'h2);
        bus(1'b0, 9'h040, 32'd0, 2'd0);
        check("R10 read zero", s_rdata, 32'd0);
        check("R10 read flag", 32'(s_bw), 32'd1);

        // R11 bad address and scaler range
        rd(9'h1E0);
        check("R11 unmapped read", s_rdata, 32'd0);
        check("R11 unmapped flag", 32'(s_ba), 32'd1);
        wr(9'h042, 32'h0000_0002);
        check("R11 unaligned flag", 32'(s_ba), 32'd1);
        rd(9'h040); check("R11 unaligned ignored", s_rdata, 32'h1);
        wr(9'h144, 32'h1234_5678);
        check("R11 gap flag", 32'(s_ba), 32'd1);
        wr(9'h0C0, 32'hFFFF_FFFF);
        check("R11 hole no flag", 32'(s_ba), 32'd0);
        rd(9'h0C0); check("R11 hole reads zero", s_rdata, 32'd0);

        // R12 selective invalidate
        wr(9'h060, 32'h5);
        check("R12 line no pulse", 32'(s_inv), 32'd0);
        wr(9'h04C, 32'h123456);
        check("R12 colour pulse", 32'(s_inv), 32'd1);

        // R9 soft reset
        wr(9'h01C, 32'h0000_0001);
        pulse_evt(16'h0001);
        wr(9'h010, 32'hFFFF_FFFF);
        check("R9 ready low", 32'(s_ready), 32'd0);
        check("R9 irq cleared", 32'(irq), 32'd0);
        check("R9 outputs cleared", {30'd0, lcd_en, gfx_en}, 32'd0);
        rd(9'h010); check("R9 idle value", s_rdata, 32'h301B);
        rd(9'h01C); check("R9 enable cleared", s_rdata, 32'd0);
        rd(9'h018); check("R9 status cleared", s_rdata, 32'd0);
        rd(9'h048); check("R9 caps reset", s_rdata, 32'h161);
        rd(9'h0AC); check("R9 row inc reset", s_rdata, 32'h1);

        finish_run();
    end

endmodule